// File: doc/BRIEF.md
# Sequential Floating-Point Divider

This block divides one binary floating-point operand by another, with a format of one sign bit, an exponent field and a fraction field, and a hidden leading one. With the default parameters the format is the 32-bit single-precision layout: sign in bit 31, an 8-bit exponent with a bias of 127 in bits 30..23, and a 23-bit fraction in bits 22..0. A caller places both operands on the inputs and raises `start` for one clock while the unit is idle. The unit then works on its own and reports the packed quotient and four exception flags together with a one-cycle `done` pulse.

The significand quotient comes from a radix-2 non-restoring loop. The loop produces one quotient bit per clock and uses a single adder/subtractor, which adds or subtracts the divisor depending on the sign of the running remainder. After the loop, one correction step makes the remainder non-negative. Three quotient bits below the result fraction, together with the nonzero test on the corrected remainder, drive a round-to-nearest-even step. Special operands skip the loop and finish in a single step. Denormal inputs are treated as zero, and results too small to be normal are flushed to zero.

Top module: `fpdiv_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `result` and all four flags are 0.
- R2: A `start` seen while `busy` is 0 is accepted. `busy` is 1 from the next cycle until the cycle in which `done` is 1. `done` is high for exactly one cycle. A `start` while `busy` is 1 is ignored. `result` and the flags hold their values until the next `done`.
- R3: For two finite nonzero normal operands, `done` is 1 in the cycle after the (2*FRAC_W+6)-th rising edge counted from the accepting edge, which is 12 edges for a 3-bit fraction. For any special case in R9..R13, `done` is 1 after the first edge that follows the accepting edge.
- R4: The result sign is the XOR of the operand signs (bit W-1), except for NaN results.
- R5: For finite normal operands, the biased result exponent is ea - eb + bias. It is one less when the dividend fraction is smaller than the divisor fraction.
- R6: The result fraction is the exact significand quotient, normalised into [1,2) and rounded to nearest with ties to even.
- R7: If the R5 exponent is at or above the all-ones exponent, the result is a signed infinity (exponent all ones, fraction 0) and `flag_ovf` is 1. At most one flag is 1 at any time.
- R8: If the R5 exponent is 0 or below, the result is a signed zero and `flag_unf` is 1.
- R9: A finite nonzero dividend divided by zero gives a signed infinity and sets `flag_dz`.
- R10: Zero divided by zero, and infinity divided by infinity, give the canonical NaN and set `flag_inv`. The canonical NaN has sign 0, an all-ones exponent, and only the fraction MSB set (0x7FC00000 by default).
- R11: If either operand is a NaN (all-ones exponent, nonzero fraction), the result is the canonical NaN and no flag is set.
- R12: A zero dividend with a nonzero divisor, or a finite dividend with an infinite divisor, gives a signed zero. An infinite dividend with a finite divisor, including zero, gives a signed infinity. Neither case sets a flag.
- R13: An operand with an exponent field of 0 is handled as a signed zero, whatever its fraction.
- R14: The operands are captured at the accepting edge. Later changes on `opa` and `opb` while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division while idle |
| opa | input | 1+EXP_W+FRAC_W | Dividend |
| opb | input | 1+EXP_W+FRAC_W | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1+EXP_W+FRAC_W | Packed quotient |
| flag_dz | output | 1 | Finite nonzero value divided by zero |
| flag_inv | output | 1 | Invalid operation (0/0, inf/inf) |
| flag_ovf | output | 1 | Result exponent too large |
| flag_unf | output | 1 | Result exponent too small, flushed to zero |

## Verification
The hardest cases to reach are the rounding ties and the off-by-one remainders. In these cases the correction step and the sticky bit decide the last fraction bit, and they occur only for particular fraction pairs. The bench builds the unit with a 4-bit exponent and a 3-bit fraction and sweeps every normal dividend against every divisor fraction at the lowest, middle and highest exponents. This covers all of these fraction pairs and drives the exponent past both range limits. Every third operation also changes the operands and pulses `start` while busy.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_FIN  = 2'd3
  } div_state_e;

endpackage

// File: rtl/fpdiv_classify.sv
module fpdiv_classify
  import fpdiv_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output fp_class_e               cls
);

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    ex = mag[EXP_W+FRAC_W-1:FRAC_W];
    fr = mag[FRAC_W-1:0];
    if (ex == '0) begin
      cls = CLS_ZERO;
    end else if (&ex) begin
      cls = (fr == '0) ? CLS_INF : CLS_NAN;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/fpdiv_nr_core.sv
module fpdiv_nr_core #(
  parameter int SIG_W = 24,
  parameter int QW    = 50,
  parameter int AW    = 26,
  parameter int OUT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             fix,
  input  logic [SIG_W-1:0] dvd_sig,
  input  logic [SIG_W-1:0] dvs_sig,
  output logic [OUT_W-1:0] quo,
  output logic             rem_nz
);

  localparam int PAD_W = QW - SIG_W;

  logic [AW-1:0]    part_q, part_d;
  logic [QW-1:0]    qreg_q, qreg_d;
  logic [SIG_W-1:0] dvs_q,  dvs_d;
  logic [AW-1:0]    dvs_ext, part_sh, part_upd;
  logic [QW-1:0]    qreg_sh;
  logic             reg_en;

  always_comb begin
    dvs_ext  = {{(AW-SIG_W){1'b0}}, dvs_q};
    part_sh  = {part_q[AW-2:0], qreg_q[QW-1]};
    qreg_sh  = {qreg_q[QW-2:0], 1'b0};
    part_upd = part_sh[AW-1] ? (part_sh + dvs_ext) : (part_sh - dvs_ext);

    reg_en = load | step | fix;
    part_d = part_q;
    qreg_d = qreg_q;
    dvs_d  = dvs_q;
    if (load) begin
      part_d = '0;
      qreg_d = {dvd_sig, {PAD_W{1'b0}}};
      dvs_d  = dvs_sig;
    end else if (step) begin
      part_d = part_upd;
      qreg_d = {qreg_sh[QW-1:1], ~part_upd[AW-1]};
    end else if (fix) begin
      if (part_q[AW-1]) begin
        part_d = part_q + dvs_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      qreg_q <= '0;
      dvs_q  <= '0;
    end else if (reg_en) begin
      part_q <= part_d;
      qreg_q <= qreg_d;
      dvs_q  <= dvs_d;
    end
  end

  assign quo    = qreg_q[OUT_W-1:0];
  assign rem_nz = |part_q;

endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 27
) (
  input  logic                    sign,
  input  logic [EXP_W-1:0]        exp_a,
  input  logic [EXP_W-1:0]        exp_b,
  input  logic [OUT_W-1:0]        quo,
  input  logic                    rem_nz,
  output logic [EXP_W+FRAC_W:0]   res,
  output logic                    ovf,
  output logic                    unf
);

  localparam int KP   = OUT_W - 1;
  localparam int EW2  = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [EW2-1:0] BIAS_S = EW2'(BIAS);
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
  localparam logic signed [EW2-1:0] ZERO_S = '0;

  logic                     hi, rnd, stk, inc;
  logic [FRAC_W-1:0]        frac_pre, frac_fin;
  logic signed [EW2-1:0]    ea_s, eb_s, dec_s, e_fin;

  always_comb begin
    hi = quo[KP];
    if (hi) begin
      frac_pre = quo[KP-1 -: FRAC_W];
      rnd      = quo[KP-FRAC_W-1];
      stk      = (|quo[KP-FRAC_W-2:0]) | rem_nz;
    end else begin
      frac_pre = quo[KP-2 -: FRAC_W];
      rnd      = quo[KP-FRAC_W-2];
      stk      = (|quo[KP-FRAC_W-3:0]) | rem_nz;
    end
    inc      = rnd & (stk | frac_pre[0]);
    frac_fin = frac_pre + FRAC_W'(inc);

    ea_s  = EW2'(exp_a);
    eb_s  = EW2'(exp_b);
    dec_s = EW2'(!hi);
    e_fin = ea_s - eb_s + BIAS_S - dec_s;

    ovf = (e_fin >= EMAX_S);
    unf = (e_fin <= ZERO_S);
    if (ovf) begin
      res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (unf) begin
      res = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end else begin
      res = {sign, e_fin[EXP_W-1:0], frac_fin};
    end
  end

endmodule

// File: rtl/fpdiv_seq.sv
module fpdiv_seq
  import fpdiv_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opa,
  input  logic [EXP_W+FRAC_W:0] opb,
  output logic                  busy,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flag_dz,
  output logic                  flag_inv,
  output logic                  flag_ovf,
  output logic                  flag_unf
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int XB    = FRAC_W + 3;
  localparam int QW    = SIG_W + XB;
  localparam int AW    = FRAC_W + 3;
  localparam int OUT_W = XB + 1;
  localparam int CNT_W = $clog2(QW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QW - 1);

  div_state_e          st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                accept, load, step, fix;

  logic [1:0][W-2:0]   mags;
  fp_class_e           cls [2];

  logic                sgn, sp_hit, sp_dz, sp_inv;
  logic [W-1:0]        sp_res, inf_w, zero_w, nan_w;

  logic                sign_q, sp_q, sdz_q, sinv_q;
  logic [EXP_W-1:0]    ea_q, eb_q;
  logic [W-1:0]        sres_q;

  logic [OUT_W-1:0]    quo;
  logic                rem_nz, r_ovf, r_unf;
  logic [W-1:0]        r_res;

  logic                done_q, fdz_q, finv_q, fovf_q, funf_q;
  logic [W-1:0]        res_q, res_d;
  logic                fdz_d, finv_d, fovf_d, funf_d, out_en;

  assign mags[0] = opa[W-2:0];
  assign mags[1] = opb[W-2:0];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpdiv_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .mag(mags[g]),
      .cls(cls[g])
    );
  end

  // special-operand resolution, evaluated on the inputs at acceptance
  always_comb begin
    sgn    = opa[W-1] ^ opb[W-1];
    inf_w  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    zero_w = {sgn, {(W-1){1'b0}}};
    nan_w  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    sp_hit = 1'b1;
    sp_res = zero_w;
    sp_dz  = 1'b0;
    sp_inv = 1'b0;
    if (cls[0] == CLS_NAN || cls[1] == CLS_NAN) begin
      sp_res = nan_w;
    end else if ((cls[0] == CLS_ZERO && cls[1] == CLS_ZERO) ||
                 (cls[0] == CLS_INF  && cls[1] == CLS_INF)) begin
      sp_res = nan_w;
      sp_inv = 1'b1;
    end else if (cls[0] == CLS_INF) begin
      sp_res = inf_w;
    end else if (cls[1] == CLS_ZERO) begin
      sp_res = inf_w;
      sp_dz  = 1'b1;
    end else if (cls[0] == CLS_ZERO || cls[1] == CLS_INF) begin
      sp_res = zero_w;
    end else begin
      sp_hit = 1'b0;
    end
  end

  // control next state
  always_comb begin
    accept = (st_q == ST_IDLE) && start;
    st_d   = st_q;
    cnt_d  = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = sp_hit ? ST_FIN : ST_RUN;
          cnt_d = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          st_d = ST_FIX;
        end
      end
      ST_FIX:  st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
    load = accept;
    step = (st_q == ST_RUN);
    fix  = (st_q == ST_FIX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // operand context captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      ea_q   <= '0;
      eb_q   <= '0;
      sp_q   <= 1'b0;
      sres_q <= '0;
      sdz_q  <= 1'b0;
      sinv_q <= 1'b0;
    end else if (accept) begin
      sign_q <= sgn;
      ea_q   <= opa[W-2 -: EXP_W];
      eb_q   <= opb[W-2 -: EXP_W];
      sp_q   <= sp_hit;
      sres_q <= sp_res;
      sdz_q  <= sp_dz;
      sinv_q <= sp_inv;
    end
  end

  fpdiv_nr_core #(
    .SIG_W(SIG_W),
    .QW   (QW),
    .AW   (AW),
    .OUT_W(OUT_W)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .fix    (fix),
    .dvd_sig({1'b1, opa[FRAC_W-1:0]}),
    .dvs_sig({1'b1, opb[FRAC_W-1:0]}),
    .quo    (quo),
    .rem_nz (rem_nz)
  );

  fpdiv_round #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .OUT_W (OUT_W)
  ) u_round (
    .sign  (sign_q),
    .exp_a (ea_q),
    .exp_b (eb_q),
    .quo   (quo),
    .rem_nz(rem_nz),
    .res   (r_res),
    .ovf   (r_ovf),
    .unf   (r_unf)
  );

  // output next state
  always_comb begin
    out_en = (st_q == ST_FIN);
    if (sp_q) begin
      res_d  = sres_q;
      fdz_d  = sdz_q;
      finv_d = sinv_q;
      fovf_d = 1'b0;
      funf_d = 1'b0;
    end else begin
      res_d  = r_res;
      fdz_d  = 1'b0;
      finv_d = 1'b0;
      fovf_d = r_ovf;
      funf_d = r_unf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      fdz_q  <= 1'b0;
      finv_q <= 1'b0;
      fovf_q <= 1'b0;
      funf_q <= 1'b0;
    end else begin
      done_q <= out_en;
      if (out_en) begin
        res_q  <= res_d;
        fdz_q  <= fdz_d;
        finv_q <= finv_d;
        fovf_q <= fovf_d;
        funf_q <= funf_d;
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign result   = res_q;
  assign flag_dz  = fdz_q;
  assign flag_inv = finv_q;
  assign flag_ovf = fovf_q;
  assign flag_unf = funf_q;

endmodule

// File: rtl/fpdiv_seq_chk.sv
module fpdiv_seq_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  flag_dz,
  input logic                  flag_inv,
  input logic                  flag_ovf,
  input logic                  flag_unf
);

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_dz, flag_inv, flag_ovf, flag_unf})); // R7
  AST_OVF_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> (result[W-2:0] == INF_MAG)); // R7
  AST_UNF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> (result[W-2:0] == '0)); // R8
  AST_DZ_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
    flag_dz |-> (result[W-2:0] == INF_MAG)); // R9
  AST_INV_GIVES_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |-> (result == QNAN)); // R10

endmodule

bind fpdiv_seq fpdiv_seq_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .flag_dz (flag_dz),
  .flag_inv(flag_inv),
  .flag_ovf(flag_ovf),
  .flag_unf(flag_unf)
);

// File: tb/test_fpdiv_seq.sv
`timescale 1ns/1ps
module test_fpdiv_seq;

  localparam int EW = 4;
  localparam int FW = 3;
  localparam int NORMAL_LAT  = 2 * FW + 6;
  localparam int SPECIAL_LAT = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] opa, opb;
  logic       busy, done;
  logic [7:0] result;
  logic       flag_dz, flag_inv, flag_ovf, flag_unf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpdiv_seq #(
    .EXP_W (EW),
    .FRAC_W(FW)
  ) i_fpdiv_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opa     (opa),
    .opb     (opb),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .flag_dz (flag_dz),
    .flag_inv(flag_inv),
    .flag_ovf(flag_ovf),
    .flag_unf(flag_unf)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int cls_of(input logic [7:0] x);
    if (x[6:3] == 4'd0) return 0;
    if (x[6:3] == 4'hF) return (x[2:0] == 3'd0) ? 2 : 3;
    return 1;
  endfunction

  // {dz, inv, ovf, unf, result}
  function automatic logic [11:0] exp_ref(input logic [7:0] a, input logic [7:0] b);
    int ca, cb, xa, xb, num, qv, r, e, adj;
    logic s;
    ca = cls_of(a);
    cb = cls_of(b);
    s  = a[7] ^ b[7];
    if (ca == 3 || cb == 3) return {4'b0000, 8'h7C};
    if ((ca == 0 && cb == 0) || (ca == 2 && cb == 2)) return {4'b0100, 8'h7C};
    if (ca == 2) return {4'b0000, s, 7'h78};
    if (cb == 0) return {4'b1000, s, 7'h78};
    if (ca == 0 || cb == 2) return {4'b0000, s, 7'h00};
    xa = 8 + int'(a[2:0]);
    xb = 8 + int'(b[2:0]);
    if (xa >= xb) begin adj = 0;  num = xa * 8;  end
    else          begin adj = -1; num = xa * 16; end
    qv = num / xb;
    r  = num % xb;
    if (2 * r > xb || (2 * r == xb && (qv % 2) == 1)) qv++;
    e = int'(a[6:3]) - int'(b[6:3]) + 7 + adj;
    if (qv == 16) begin qv = 8; e++; end
    if (e >= 15) return {4'b0010, s, 7'h78};
    if (e <= 0)  return {4'b0001, s, 7'h00};
    return {4'b0000, s, e[3:0], qv[2:0]};
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit disturb,
                        output logic [7:0] r, output logic [3:0] fl, output int lat);
    @(negedge clk);
    opa   = a;
    opb   = b;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {30'd0, busy, done}, 32'h2);
    lat = 0;
    while (done !== 1'b1 && lat < 80) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (disturb && done !== 1'b1) begin
        opa   = ~a;
        opb   = ~b;
        start = (lat == 1);
      end
    end
    start = 1'b0;
    r  = result;
    fl = {flag_dz, flag_inv, flag_ovf, flag_unf};
    chk(busy === 1'b0, "R2 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R2 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic do_case(input logic [7:0] a, input logic [7:0] b, input bit disturb, input string tag);
    logic [7:0]  r;
    logic [3:0]  fl;
    logic [11:0] ex;
    int          lat, ca, cb;
    ex = exp_ref(a, b);
    ca = cls_of(a);
    cb = cls_of(b);
    run_op(a, b, disturb, r, fl, lat);
    chk({fl, r} === ex, tag, {20'd0, fl, r}, {20'd0, ex});
    if (ca == 1 && cb == 1)
      chk(lat == NORMAL_LAT, "R3 normal latency", lat, NORMAL_LAT);
    else
      chk(lat == SPECIAL_LAT, "R3 special latency", lat, SPECIAL_LAT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int          n;
    logic [3:0]  ebs [3];
    logic [11:0] ex;
    string       tag;
    ebs[0] = 4'd1; ebs[1] = 4'd7; ebs[2] = 4'd14;
    rst_n = 1'b0;
    start = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, result, flag_dz, flag_inv, flag_ovf, flag_unf} === 14'd0,
        "R1 reset state", {18'd0, busy, done, result, flag_dz, flag_inv, flag_ovf, flag_unf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, result} === 10'd0, "R1 after release", {22'd0, busy, done, result}, 32'd0);

    // special operands
    do_case(8'h00, 8'h80, 1'b0, "R10 zero/zero");
    do_case(8'h78, 8'hF8, 1'b0, "R10 inf/inf");
    do_case(8'h38, 8'h80, 1'b0, "R9 one/-zero");
    do_case(8'hC5, 8'h00, 1'b0, "R9 neg/zero");
    do_case(8'h7C, 8'h38, 1'b0, "R11 nan dividend");
    do_case(8'h38, 8'hFF, 1'b0, "R11 nan divisor");
    do_case(8'h7A, 8'h00, 1'b0, "R11 nan over zero");
    do_case(8'h00, 8'hC0, 1'b0, "R12 zero/-two");
    do_case(8'h38, 8'h78, 1'b0, "R12 one/inf");
    do_case(8'hF8, 8'h40, 1'b0, "R12 -inf/two");
    do_case(8'h78, 8'h80, 1'b0, "R12 inf/zero");
    do_case(8'h03, 8'h38, 1'b0, "R13 denorm dividend");
    do_case(8'h38, 8'h83, 1'b0, "R13 denorm divisor");
    do_case(8'h05, 8'h07, 1'b0, "R13 denorm/denorm");

    // sweep: every normal dividend against three divisor exponents
    n = 0;
    for (int ea = 1; ea < 15; ea++) begin
      for (int fa = 0; fa < 8; fa++) begin
        for (int k = 0; k < 3; k++) begin
          for (int fb = 0; fb < 8; fb++) begin
            logic [7:0] a, b;
            a  = {1'(fa ^ ea), 4'(ea), 3'(fa)};
            b  = {1'(fb >> 1), ebs[k], 3'(fb)};
            ex = exp_ref(a, b);
            if ((n % 3) == 2)   tag = "R14 operands changed while busy";
            else if (ex[9])     tag = "R7 overflow";
            else if (ex[8])     tag = "R8 underflow";
            else                tag = "R4 R5 R6 quotient";
            do_case(a, b, (n % 3) == 2, tag);
            n++;
          end
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule